// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Hours

This block keeps the time of day and the calendar date as seven packed-BCD registers: seconds, minutes, hours, weekday, date, month and two-digit year (00 to 99, meaning 2000 to 2099). A sub-second pulse input `sub_tick` is divided by the parameter `TICKS_PER_SEC`. When the divider completes, the clock advances by one second. The advance carries through minutes, hours, date, month and year. Month lengths and leap Februaries follow the two-digit year.

The hour register has two encodings, selected by its bit 6. With bit 6 clear, the hour counts 00 to 23 in BCD. With bit 6 set, bits 4..0 hold a BCD hour from 1 to 12 and bit 5 means PM. In this mode 11 goes to 12 and flips AM/PM, and 12 goes to 1 and keeps the PM bit. The day rolls over when the clock leaves 11 PM.

A register port updates any field on the next clock edge. A combinational read port returns any field. The `run` input gates all counting and models the oscillator run control. A write to seconds restarts the sub-second divider, so the first advance after that write comes a full second later.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Seconds and minutes count in BCD from 00 to 59. Each wraps to 00 and carries into the next field. Seconds advance once for every `TICKS_PER_SEC` accepted sub-ticks.
- R3: With hour bit 6 clear, the hour counts 0x00 to 0x23. Leaving 0x23 wraps it to 0x00 and advances the date.
- R4: With hour bit 6 set, bit 5 is PM and bits 4..0 count 1 to 12. Leaving 11 gives 12 with bit 5 inverted. Leaving 12 gives 1 with bit 5 kept. Only leaving 11 PM advances the date. Bit 6 stays set while counting.
- R5: The date wraps to 01 after day 30 in months 0x04, 0x06, 0x09 and 0x11. It wraps after day 31 in the other months. In February it wraps after 29 when the year value is a multiple of four, and after 28 otherwise.
- R6: A date wrap advances the month. Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R7: The weekday advances on every date advance. After 7 it returns to 1.
- R8: While `run` is low, sub-ticks are ignored, and neither the time nor the divider phase changes.
- R9: A write with `wr_en` high at address 0..6 (seconds 0, minutes 1, hours 2, weekday 3, date 4, month 5, year 6) stores the data at the next clock edge. Bits beyond the field width are dropped (seconds, minutes and hours keep 7 bits, weekday 3, date 6, month 5, year 8). A sub-tick in the same cycle as any write is discarded.
- R10: A write to seconds clears the divider phase, so exactly `TICKS_PER_SEC` further sub-ticks are needed before the next second.
- R11: `rd_data` shows the addressed field with its unused upper bits zero. Address 7 reads 0x00, and writes to address 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High lets the clock count |
| sub_tick | input | 1 | Sub-second pulse; `TICKS_PER_SEC` of them make one second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data (packed BCD) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |

## Verification
Every effect of this block is due one clock after its cause, and the read data is combinational:
- A write appears on `rd_data` after the rising edge that samples `wr_en`.
- A second is added after the edge that samples the `TICKS_PER_SEC`-th accepted sub-tick, and any carries land on that same edge.

Stimulus changes on falling edges, and a reference model advances on every rising edge. On each falling edge, one register (rotating through all seven) is compared against the model, half a period after the edge that updated it. Targeted probes at the end of each scenario pin down the expected BCD bytes for year, month, leap-day, 12-hour and divider corner cases.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

   localparam logic [2:0] ADDR_SEC   = 3'd0;
   localparam logic [2:0] ADDR_MIN   = 3'd1;
   localparam logic [2:0] ADDR_HOUR  = 3'd2;
   localparam logic [2:0] ADDR_WDAY  = 3'd3;
   localparam logic [2:0] ADDR_DATE  = 3'd4;
   localparam logic [2:0] ADDR_MONTH = 3'd5;
   localparam logic [2:0] ADDR_YEAR  = 3'd6;

   // Hour register flag positions (decoded by the counter)
   localparam int HOUR_MODE12_BIT = 6;
   localparam int HOUR_PM_BIT     = 5;

   // Two-digit BCD increment (no range wrap; callers handle limits)
   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      else
         return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Year (BCD) divisible by four: tens even -> ones 0/4/8, tens odd -> ones 2/6
   function automatic logic year_is_leap(input logic [7:0] yr);
      if (yr[4])
         return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      else
         return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
   endfunction

   // Last day (BCD) of a BCD month in a BCD year
   function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return year_is_leap(yr) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcdcal_phase.sv
module bcdcal_phase #(
   parameter int TICKS_PER_SEC = 4,
   localparam int PHASE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               clr,
   output logic               sec_tick,
   output logic [PHASE_W-1:0] phase
);

   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         // Every accepted sub-tick is a whole second
         assign sec_tick = adv;
         assign phase    = '0;
      end else begin : g_divide
         logic [PHASE_W-1:0] cnt_q;
         logic               last;

         assign last     = (cnt_q == PHASE_W'(TICKS_PER_SEC - 1));
         assign sec_tick = adv & last;
         assign phase    = cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr)
               cnt_q <= '0;
            else if (adv)
               cnt_q <= last ? '0 : cnt_q + PHASE_W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/bcdcal_time.sv
module bcdcal_time
   import bcdcal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [6:0] sec,
   output logic [6:0] min,
   output logic [6:0] hour,
   output logic       day_carry
);

   logic [6:0] sec_q, min_q, hour_q, hour_d;
   logic       sec_wrap, min_wrap, hour_day;
   logic       mode12, pm;

   assign sec_wrap = (sec_q == 7'h59);
   assign min_wrap = (min_q == 7'h59);
   assign mode12   = hour_q[HOUR_MODE12_BIT];
   assign pm       = hour_q[HOUR_PM_BIT];

   // Next hour value and whether leaving this hour ends the day
   always_comb begin
      hour_d   = hour_q;
      hour_day = 1'b0;
      if (mode12) begin
         if (hour_q[4:0] == 5'h11) begin
            hour_d   = {1'b1, ~pm, 5'h12};
            hour_day = pm;
         end else if (hour_q[4:0] == 5'h12) begin
            hour_d = {1'b1, pm, 5'h01};
         end else begin
            hour_d = {1'b1, pm, 5'(bcd_next({3'b000, hour_q[4:0]}))};
         end
      end else begin
         if (hour_q[5:0] == 6'h23) begin
            hour_d   = 7'h00;
            hour_day = 1'b1;
         end else begin
            hour_d = {1'b0, 6'(bcd_next({2'b00, hour_q[5:0]}))};
         end
      end
   end

   assign day_carry = sec_tick & sec_wrap & min_wrap & hour_day;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= 7'h00;
         min_q  <= 7'h00;
         hour_q <= 7'h00;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_SEC:  sec_q  <= wr_data[6:0];
            ADDR_MIN:  min_q  <= wr_data[6:0];
            ADDR_HOUR: hour_q <= wr_data[6:0];
            default:   ;
         endcase
      end else if (sec_tick) begin
         sec_q <= sec_wrap ? 7'h00 : 7'(bcd_next({1'b0, sec_q}));
         if (sec_wrap) begin
            min_q <= min_wrap ? 7'h00 : 7'(bcd_next({1'b0, min_q}));
            if (min_wrap)
               hour_q <= hour_d;
         end
      end
   end

   assign sec  = sec_q;
   assign min  = min_q;
   assign hour = hour_q;

endmodule

// File: rtl/bcdcal_date.sv
module bcdcal_date
   import bcdcal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       day_carry,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [2:0] wday,
   output logic [5:0] date,
   output logic [4:0] month,
   output logic [7:0] year
);

   logic [2:0] wday_q;
   logic [5:0] date_q;
   logic [4:0] mon_q;
   logic [7:0] year_q;
   logic       date_wrap, mon_wrap;

   assign date_wrap = (date_q == month_last(mon_q, year_q));
   assign mon_wrap  = (mon_q == 5'h12);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wday_q <= 3'd1;
         date_q <= 6'h01;
         mon_q  <= 5'h01;
         year_q <= 8'h00;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_WDAY:  wday_q <= wr_data[2:0];
            ADDR_DATE:  date_q <= wr_data[5:0];
            ADDR_MONTH: mon_q  <= wr_data[4:0];
            ADDR_YEAR:  year_q <= wr_data;
            default:    ;
         endcase
      end else if (day_carry) begin
         wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
         if (date_wrap) begin
            date_q <= 6'h01;
            if (mon_wrap) begin
               mon_q  <= 5'h01;
               year_q <= (year_q == 8'h99) ? 8'h00 : bcd_next(year_q);
            end else begin
               mon_q <= 5'(bcd_next({3'b000, mon_q}));
            end
         end else begin
            date_q <= 6'(bcd_next({2'b00, date_q}));
         end
      end
   end

   assign wday  = wday_q;
   assign date  = date_q;
   assign month = mon_q;
   assign year  = year_q;

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import bcdcal_pkg::*;
#(
   parameter int TICKS_PER_SEC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       sub_tick,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data
);

   localparam int PHASE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

   generate
      if (TICKS_PER_SEC < 1) begin : g_bad_rate
         $error("bcd_calendar: TICKS_PER_SEC must be at least 1");
      end
   endgenerate

   logic               adv, clr, sec_tick, day_carry;
   logic [PHASE_W-1:0] phase;
   logic [6:0]         sec, min, hour;
   logic [2:0]         wday;
   logic [5:0]         date;
   logic [4:0]         month;
   logic [7:0]         year;

   // A write cycle swallows any sub-tick that arrives with it
   assign adv = sub_tick & run & ~wr_en;
   assign clr = wr_en & (wr_addr == ADDR_SEC);

   bcdcal_phase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_phase (
      .clk(clk), .rst_n(rst_n), .adv(adv), .clr(clr),
      .sec_tick(sec_tick), .phase(phase)
   );

   bcdcal_time u_time (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sec(sec), .min(min), .hour(hour), .day_carry(day_carry)
   );

   bcdcal_date u_date (
      .clk(clk), .rst_n(rst_n), .day_carry(day_carry),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wday(wday), .date(date), .month(month), .year(year)
   );

   always_comb begin
      case (rd_addr)
         ADDR_SEC:   rd_data = {1'b0, sec};
         ADDR_MIN:   rd_data = {1'b0, min};
         ADDR_HOUR:  rd_data = {1'b0, hour};
         ADDR_WDAY:  rd_data = {5'b0, wday};
         ADDR_DATE:  rd_data = {2'b0, date};
         ADDR_MONTH: rd_data = {3'b0, month};
         ADDR_YEAR:  rd_data = year;
         default:    rd_data = 8'h00;
      endcase
   end

endmodule

// File: rtl/bcdcal_checker.sv
module bcdcal_checker #(
   parameter int TICKS_PER_SEC = 4,
   localparam int PHASE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               sub_tick,
   input logic               wr_en,
   input logic [2:0]         wr_addr,
   input logic [7:0]         wr_data,
   input logic [6:0]         sec,
   input logic [6:0]         hour,
   input logic [2:0]         wday,
   input logic [5:0]         date,
   input logic [PHASE_W-1:0] phase
);

   assert_sec_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && (sec != $past(sec))) |-> $past(sub_tick && run));

   assert_mode12_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hour[6] && !wr_en) |=> hour[6]);

   assert_wday_with_date_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && (wday != $past(wday))) |-> (date != $past(date)));

   assert_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> ($stable(sec) && $stable(date) && $stable(phase)));

   assert_sec_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == 3'd0)) |=> (sec == $past(wr_data[6:0])));

   assert_phase_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == 3'd0)) |=> (phase == '0));

endmodule

bind bcd_calendar bcdcal_checker #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .sub_tick(sub_tick),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .sec(sec), .hour(hour), .wday(wday), .date(date), .phase(phase)
);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;

   localparam int TPS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b1;
   logic       sub_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [2:0] rd_addr = 3'd0;
   logic [7:0] rd_data;

   logic [2:0] probe_addr = 3'd0;
   logic       probe_en = 1'b0;

   int n_run = 0;
   int n_bad = 0;

   // Reference state, kept as plain integers
   int m_s, m_m, m_h, m_wd, m_dt, m_mo, m_yr, m_ph;
   bit m_12;

   always #10 clk = ~clk;

   bcd_calendar #(.TICKS_PER_SEC(TPS)) u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .sub_tick(sub_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic int to_bcd(int v);
      return (v / 10) * 16 + (v % 10);
   endfunction

   function automatic int from_bcd(int b);
      return (b / 16) * 10 + (b % 16);
   endfunction

   function automatic int days_in(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic int model_byte(int a);
      int h12;
      case (a)
         0: return to_bcd(m_s);
         1: return to_bcd(m_m);
         2: begin
            if (!m_12) return to_bcd(m_h);
            h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
            return 64 + ((m_h >= 12) ? 32 : 0) + to_bcd(h12);
         end
         3: return m_wd;
         4: return to_bcd(m_dt);
         5: return to_bcd(m_mo);
         6: return to_bcd(m_yr);
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int a);
      case (a)
         0, 1:    return "R2";
         2:       return m_12 ? "R4" : "R3";
         3:       return "R7";
         4:       return "R5";
         5, 6:    return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic model_second();
      m_s = m_s + 1;
      if (m_s < 60) return;
      m_s = 0;
      m_m = m_m + 1;
      if (m_m < 60) return;
      m_m = 0;
      m_h = m_h + 1;
      if (m_h < 24) return;
      m_h = 0;
      m_wd = (m_wd == 7) ? 1 : m_wd + 1;
      if (m_dt < days_in(m_mo, m_yr)) begin
         m_dt = m_dt + 1;
         return;
      end
      m_dt = 1;
      if (m_mo < 12) begin
         m_mo = m_mo + 1;
         return;
      end
      m_mo = 1;
      m_yr = (m_yr + 1) % 100;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s = 0; m_m = 0; m_h = 0; m_12 = 0;
         m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_ph = 0;
      end else if (wr_en) begin
         case (wr_addr)
            3'd0: begin m_s = from_bcd(int'(wr_data & 8'h7f)); m_ph = 0; end
            3'd1: m_m = from_bcd(int'(wr_data & 8'h7f));
            3'd2: begin
               if (wr_data[6]) begin
                  m_12 = 1;
                  m_h  = (from_bcd(int'(wr_data & 8'h1f)) % 12) + (wr_data[5] ? 12 : 0);
               end else begin
                  m_12 = 0;
                  m_h  = from_bcd(int'(wr_data & 8'h3f));
               end
            end
            3'd3: m_wd = int'(wr_data & 8'h07);
            3'd4: m_dt = from_bcd(int'(wr_data & 8'h3f));
            3'd5: m_mo = from_bcd(int'(wr_data & 8'h1f));
            3'd6: m_yr = from_bcd(int'(wr_data));
            default: ;
         endcase
      end else if (sub_tick && run) begin
         if (m_ph == TPS - 1) begin
            m_ph = 0;
            model_second();
         end else begin
            m_ph = m_ph + 1;
         end
      end
   end

   // Continuous comparison of one rotating register per falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         n_run++;
         if (int'(rd_data) != model_byte(int'(rd_addr))) begin
            n_bad++;
            $display("FAIL %s reg %0d actual %h expected %h", tag_of(int'(rd_addr)),
                     rd_addr, rd_data, model_byte(int'(rd_addr)));
         end
      end
      rd_addr <= probe_en ? probe_addr : ((rd_addr == 3'd6) ? 3'd0 : rd_addr + 3'd1);
   end

   task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
      probe_addr = a;
      probe_en   = 1'b1;
      @(negedge clk);
      #1;
      n_run++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s probe reg %0d actual %h expected %h", tag, a, rd_data, exp);
      end
      probe_en = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         @(negedge clk);
         sub_tick = 1'b1;
      end
      @(negedge clk);
      sub_tick = 1'b0;
   endtask

   // Load hh:59:59 style time; seconds written last so the phase is zero
   task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      wr(3'd2, h);
      wr(3'd1, m);
      wr(3'd0, s);
   endtask

   task automatic set_date(input logic [7:0] y, input logic [7:0] mo,
                           input logic [7:0] d, input logic [7:0] w);
      wr(3'd6, y);
      wr(3'd5, mo);
      wr(3'd4, d);
      wr(3'd3, w);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents
      peek(3'd0, 8'h00, "R1");
      peek(3'd1, 8'h00, "R1");
      peek(3'd2, 8'h00, "R1");
      peek(3'd3, 8'h01, "R1");
      peek(3'd4, 8'h01, "R1");
      peek(3'd5, 8'h01, "R1");
      peek(3'd6, 8'h00, "R1");

      // R2: 61 seconds from reset
      ticks(61 * TPS);
      peek(3'd0, 8'h01, "R2");
      peek(3'd1, 8'h01, "R2");

      // R3 R5 R6 R7: end of century rollover
      set_date(8'h99, 8'h12, 8'h31, 8'h07);
      set_time(8'h23, 8'h59, 8'h58);
      ticks(2 * TPS);
      peek(3'd0, 8'h00, "R2");
      peek(3'd2, 8'h00, "R3");
      peek(3'd3, 8'h01, "R7");
      peek(3'd4, 8'h01, "R5");
      peek(3'd5, 8'h01, "R6");
      peek(3'd6, 8'h00, "R6");

      // R5: leap year 2024, then non-leap 2023, tens-odd leap 2012, 30-day month
      set_date(8'h24, 8'h02, 8'h28, 8'h03);
      set_time(8'h23, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd4, 8'h29, "R5");
      set_time(8'h23, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd4, 8'h01, "R5");
      peek(3'd5, 8'h03, "R5");
      set_date(8'h23, 8'h02, 8'h28, 8'h03);
      set_time(8'h23, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd4, 8'h01, "R5");
      peek(3'd5, 8'h03, "R5");
      set_date(8'h12, 8'h02, 8'h28, 8'h03);
      set_time(8'h23, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd4, 8'h29, "R5");
      set_date(8'h30, 8'h04, 8'h30, 8'h02);
      set_time(8'h23, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd4, 8'h01, "R5");
      peek(3'd5, 8'h05, "R5");
      peek(3'd3, 8'h03, "R7");

      // R4: 12-hour transitions
      set_time(8'h51, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd2, 8'h72, "R4");
      set_time(8'h72, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd2, 8'h61, "R4");
      set_date(8'h30, 8'h01, 8'h05, 8'h03);
      set_time(8'h71, 8'h59, 8'h59);
      ticks(TPS);
      peek(3'd2, 8'h52, "R4");
      peek(3'd4, 8'h06, "R4");
      peek(3'd3, 8'h04, "R7");

      // R8: halted clock ignores sub-ticks and keeps phase
      set_time(8'h10, 8'h00, 8'h00);
      ticks(2);
      run = 1'b0;
      ticks(3 * TPS);
      peek(3'd0, 8'h00, "R8");
      run = 1'b1;
      ticks(TPS - 2);
      peek(3'd0, 8'h01, "R8");

      // R10: seconds write restarts the divider
      wr(3'd0, 8'h10);
      ticks(2);
      wr(3'd0, 8'h20);
      ticks(TPS - 1);
      peek(3'd0, 8'h20, "R10");
      ticks(1);
      peek(3'd0, 8'h21, "R10");

      // R9: sub-tick during a write is dropped; field masking
      ticks(TPS - 1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h42; sub_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sub_tick = 1'b0;
      peek(3'd0, 8'h21, "R9");
      peek(3'd1, 8'h42, "R9");
      ticks(1);
      peek(3'd0, 8'h22, "R9");
      wr(3'd3, 8'hff);
      peek(3'd3, 8'h07, "R9");

      // R11: address 7 reads zero and ignores writes
      wr(3'd7, 8'hff);
      peek(3'd7, 8'h00, "R11");
      peek(3'd1, 8'h42, "R11");
      peek(3'd6, 8'h30, "R11");

      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule